// File: doc/BRIEF.md
# Reset Source Capture Controller

This block gathers reset requests from the system's monitors and agents: low-voltage detection, clock loss, PLL lock loss, watchdog expiry, the external reset pin, core lockup, software, a debugger and a peripheral that failed to acknowledge a stop request. It decides when the system reset is issued and records why. Each request arrives as a single-cycle pulse on one bit of an event vector. The bit position of each event is also the bit position of its cause in the status registers.

A source whose interrupt is enabled, with the global interrupt enable also set, first raises an interrupt. The controller then counts a programmable number of low-power oscillator ticks before it issues the reset. Any other request resets at once. When the reset fires, a read-only status register is loaded with exactly the causes of that reset. A sticky register accumulates causes across resets and is cleared only by power-on or by software writing ones. The power-on input resets the whole controller and marks both the power-on and the low-voltage causes.

A 32-bit register bus with combinational read data gives access to a version word, the two cause registers, the interrupt and delay configuration, and a boot-mode field with a matching set-only force register.

Top module: `rst_cause_ctrl`

## Requirements
- R1: After `por_n` is released, status reads 0x0000_0082 at offset 0x08 and sticky reads 0x0000_0082 at offset 0x18. The interrupt-enable word (0x1C) and the mode word (0x10) read 0. The version word (0x00) reads {VER_MAJOR[7:0], VER_MINOR[7:0], 16'h0003}. `irq_o` and `sys_rst_o` are low.
- R2: Only `src_evt` bits 1 (low voltage), 2 (clock loss), 3 (lock loss), 5 (watchdog), 6 (pin), 9 (lockup), 10 (software), 11 (debugger) and 13 (stop-ack error) are requests. Pulses on any other bit change no register and no output.
- R3: Interrupt-enable bits 1:0 select the delay: code 0 gives 10, code 1 gives 34, code 2 gives 130 and code 3 gives 514 ticks of `lpo_tick`. These are counted from the cycle after the first delayed request. The reset fires on the last tick and not one tick earlier.
- R4: `irq_o` is high exactly when interrupt-enable bit 7 is set and some pending cause has its own enable set at its cause bit position (bits 2, 3, 5, 6, 9, 10, 11, 13).
- R5: A request that is not interrupt-enabled resets on the next clock edge. This covers bit 1, a source with its enable clear, and any source while bit 7 is clear. `sys_rst_o` rises for one cycle, even if a countdown is running.
- R6: A further request during a countdown does not restart it. The reset fires when the first delay ends and records every pending cause.
- R7: When the reset fires, status holds exactly the causes pending plus those arriving that cycle, and sticky ORs them in.
- R8: Writing 1 to a sticky bit clears it, and writing 0 leaves it unchanged. Writes to status and version have no effect.
- R9: The boot field is mode bits 2:1. A mode write replaces it. A write to force mode (0x14) ORs data bits 2:1 into it. Force mode reads 0.
- R10: `sys_rst_o` is a one-cycle pulse per firing, issued in the cycle after the firing edge. The countdown is cleared by it and pending causes are cleared by it.
- R11: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Power-on reset, asynchronous active low, released synchronously |
| lpo_tick | input | 1 | One-cycle enable per low-power oscillator period |
| src_evt | input | 16 | Reset request pulses, one bit per cause position |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Reset-pending interrupt |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The bench targets the exact tick count of each delay code. A design that is off by one would fire a tick early or late, and this shows on the tick before the last. It sends a second request mid-countdown: a restarting counter would push the reset out by a whole delay, and a lost cause would leave a status bit clear. It mixes unenabled requests into countdowns and clears global enable while sources stay enabled; a design that trusts the source enable alone would wait instead of resetting. Pulses on the unused event positions, writes to the read-only registers and zero-writes to the sticky register are all checked to leave state unchanged. Random traffic compares every output and register against a reference model.

// File: rtl/rcc_pkg.sv
`timescale 1ns/1ps
package rcc_pkg;
  localparam int DW    = 32;
  localparam int AW    = 5;
  localparam int EVT_W = 16;
  localparam int CNT_W = 10;

  localparam logic [DW-1:0] CAUSE_MASK = 32'h0000_2EEE;
  localparam logic [DW-1:0] SRC_MASK   = 32'h0000_2E6E;
  localparam logic [DW-1:0] IRQ_MASK   = 32'h0000_2E6C;
  localparam logic [DW-1:0] IEN_MASK   = 32'h0000_2EEF;
  localparam logic [DW-1:0] POR_CAUSE  = 32'h0000_0082;
  localparam int            GIE_BIT    = 7;
  localparam logic [15:0]   FEATURE_ID = 16'h0003;

  localparam logic [AW-1:0] A_VER    = 5'h00;
  localparam logic [AW-1:0] A_STAT   = 5'h08;
  localparam logic [AW-1:0] A_MODE   = 5'h10;
  localparam logic [AW-1:0] A_FORCE  = 5'h14;
  localparam logic [AW-1:0] A_STICKY = 5'h18;
  localparam logic [AW-1:0] A_IEN    = 5'h1C;

  localparam logic [CNT_W-1:0] MAX_DELAY = CNT_W'(514);

  // ticks = 2^(2*code+3) + 2
  function automatic logic [CNT_W-1:0] delay_ticks(input logic [1:0] code);
    logic [CNT_W-1:0] one;
    one = CNT_W'(1);
    return (one << (2 * int'(code) + 3)) + CNT_W'(2);
  endfunction
endpackage

// File: rtl/rcc_regs.sv
`timescale 1ns/1ps
module rcc_regs
  import rcc_pkg::*;
#(
  parameter int VER_MAJOR = 1,
  parameter int VER_MINOR = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] sticky_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] ien_o,
  output logic [DW-1:0] sticky_clr_o
);
  localparam logic [DW-1:0] VER_WORD = {VER_MAJOR[7:0], VER_MINOR[7:0], FEATURE_ID};

  logic [1:0]    boot_q, boot_d;
  logic [DW-1:0] ien_q, ien_d;
  logic          cfg_en;

  assign cfg_en = bus_wr;

  always_comb begin
    boot_d = boot_q;
    ien_d  = ien_q;
    case (bus_addr)
      A_MODE:  boot_d = bus_wdata[2:1];
      A_FORCE: boot_d = boot_q | bus_wdata[2:1];
      A_IEN:   ien_d  = bus_wdata & IEN_MASK;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= '0;
      ien_q  <= '0;
    end else if (cfg_en) begin
      boot_q <= boot_d;
      ien_q  <= ien_d;
    end
  end

  assign sticky_clr_o = (bus_wr && bus_addr == A_STICKY) ? (bus_wdata & CAUSE_MASK) : '0;
  assign ien_o        = ien_q;

  always_comb begin
    case (bus_addr)
      A_VER:    rdata_o = VER_WORD;
      A_STAT:   rdata_o = status_i;
      A_MODE:   rdata_o = {{(DW-3){1'b0}}, boot_q, 1'b0};
      A_STICKY: rdata_o = sticky_i;
      A_IEN:    rdata_o = ien_q;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rcc_timer.sv
`timescale 1ns/1ps
module rcc_timer
  import rcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [1:0]       code_i,
  input  logic             tick_i,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  assign done_o = act_q && tick_i && (cnt_q == CNT_W'(1));
  assign upd_en = abort_i || start_i || (act_q && tick_i);

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (abort_i) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (start_i && !act_q) begin
      act_d = 1'b1;
      cnt_d = delay_ticks(code_i);
    end else if (act_q && tick_i) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (upd_en) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign active_o = act_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/rcc_capture.sv
`timescale 1ns/1ps
module rcc_capture
  import rcc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt_i,
  input  logic [DW-1:0] ien_i,
  input  logic          fire_i,
  input  logic [DW-1:0] clr_i,
  output logic          now_o,
  output logic          delay_o,
  output logic [DW-1:0] pend_o,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] sticky_o
);
  logic [DW-1:0] pend_q, pend_d;
  logic [DW-1:0] stat_q, stat_d;
  logic [DW-1:0] stk_q, stk_d;
  logic [DW-1:0] irq_en, cause_all;

  assign irq_en    = ien_i[GIE_BIT] ? (ien_i & IRQ_MASK) : '0;
  assign now_o     = |(evt_i & ~irq_en);
  assign delay_o   = |(evt_i & irq_en);
  assign cause_all = pend_q | evt_i;

  always_comb begin
    stat_d = stat_q;
    if (fire_i) begin
      pend_d = '0;
      stat_d = cause_all;
      stk_d  = (stk_q & ~clr_i) | cause_all;
    end else begin
      pend_d = cause_all;
      stk_d  = stk_q & ~clr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      stat_q <= POR_CAUSE;
      stk_q  <= POR_CAUSE;
    end else begin
      pend_q <= pend_d;
      stk_q  <= stk_d;
      if (fire_i) stat_q <= stat_d;
    end
  end

  assign pend_o   = pend_q;
  assign status_o = stat_q;
  assign sticky_o = stk_q;
endmodule

// File: rtl/rst_cause_ctrl.sv
`timescale 1ns/1ps
module rst_cause_ctrl
  import rcc_pkg::*;
#(
  parameter int VER_MAJOR = 1,
  parameter int VER_MINOR = 0
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             lpo_tick,
  input  logic [EVT_W-1:0] src_evt,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq_o,
  output logic             sys_rst_o
);
  logic [1:0]       rsync_q;
  logic             rst_n;
  logic [DW-1:0]    evt, ien, sticky_clr, pend, status, sticky;
  logic             req_now, req_delay, tmr_done, tmr_active, fire, rst_q;
  logic [CNT_W-1:0] tmr_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  assign evt = {{(DW-EVT_W){1'b0}}, src_evt} & SRC_MASK;

  rcc_regs #(.VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .status_i(status), .sticky_i(sticky),
    .rdata_o(bus_rdata), .ien_o(ien), .sticky_clr_o(sticky_clr)
  );

  rcc_capture u_cap (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .ien_i(ien), .fire_i(fire),
    .clr_i(sticky_clr), .now_o(req_now), .delay_o(req_delay),
    .pend_o(pend), .status_o(status), .sticky_o(sticky)
  );

  rcc_timer u_tmr (
    .clk(clk), .rst_n(rst_n), .start_i(req_delay), .abort_i(fire),
    .code_i(ien[1:0]), .tick_i(lpo_tick), .active_o(tmr_active),
    .cnt_o(tmr_cnt), .done_o(tmr_done)
  );

  assign fire = req_now || tmr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= fire;
  end

  assign sys_rst_o = rst_q;
  assign irq_o     = ien[GIE_BIT] && |(pend & ien & IRQ_MASK);
endmodule

// File: rtl/rcc_chk.sv
`timescale 1ns/1ps
module rcc_chk
  import rcc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sys_rst_o,
  input logic             irq_o,
  input logic             gie,
  input logic             fire,
  input logic             tick,
  input logic             tmr_active,
  input logic [CNT_W-1:0] tmr_cnt,
  input logic [DW-1:0]    status,
  input logic [DW-1:0]    sticky
);
  a_r4_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> gie);

  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_active |-> (tmr_cnt >= CNT_W'(1) && tmr_cnt <= MAX_DELAY));

  a_r6_cnt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_active && !tick && !fire) |=> (tmr_cnt == $past(tmr_cnt)));

  a_r8_status_only_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(status));

  a_r7_status_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> (status != '0));

  a_r7_sticky_covers_status: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> ((sticky & status) == status));

  a_r10_fire_stops_timer: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !tmr_active);
endmodule

bind rst_cause_ctrl rcc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sys_rst_o(sys_rst_o), .irq_o(irq_o),
  .gie(ien[rcc_pkg::GIE_BIT]), .fire(fire), .tick(lpo_tick),
  .tmr_active(tmr_active), .tmr_cnt(tmr_cnt), .status(status), .sticky(sticky)
);

// File: tb/sim_rst_cause_ctrl.sv
`timescale 1ns/1ps
module sim_rst_cause_ctrl;
  localparam int MAJ = 2;
  localparam int MIN = 5;
  localparam logic [31:0] CM = 32'h2EEE, SM = 32'h2E6E, IM = 32'h2E6C, EM = 32'h2EEF;

  logic        clk = 1'b0;
  logic        por_n, lpo_tick, bus_wr;
  logic [15:0] src_evt;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_o, sys_rst_o;

  int n_run = 0, n_fail = 0;
  bit done_flag = 0;

  logic [31:0] m_stat, m_stk, m_pend, m_ien;
  logic [1:0]  m_boot;
  logic        m_act, m_rst, m_irq;
  int          m_cnt;

  always #5 clk = ~clk;

  rst_cause_ctrl #(.VER_MAJOR(MAJ), .VER_MINOR(MIN)) u0 (
    .clk(clk), .por_n(por_n), .lpo_tick(lpo_tick), .src_evt(src_evt),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  function automatic int dly_of(input logic [1:0] c);
    case (c)
      2'd0: return 10;
      2'd1: return 34;
      2'd2: return 130;
      default: return 514;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock cycle: drive at negedge, advance model, check outputs at next negedge
  task automatic cyc(input logic [15:0] ev, input logic tk, input logic wr,
                     input logic [4:0] a, input logic [31:0] d);
    logic [31:0] e, en, clr;
    logic imm, dly, fin, gie;
    src_evt = ev; lpo_tick = tk; bus_wr = wr; bus_addr = a; bus_wdata = d;
    e   = {16'h0, ev} & SM;
    gie = m_ien[7];
    en  = gie ? (m_ien & IM) : 32'h0;
    imm = |(e & ~en);
    dly = |(e & en);
    fin = m_act && tk && (m_cnt == 1);
    clr = (wr && a == 5'h18) ? (d & CM) : 32'h0;
    if (imm || fin) begin
      m_stat = m_pend | e;
      m_stk  = (m_stk & ~clr) | m_pend | e;
      m_pend = 0;
      m_act  = 0;
      m_cnt  = 0;
    end else begin
      m_pend = m_pend | e;
      m_stk  = m_stk & ~clr;
      if (dly && !m_act) begin m_act = 1; m_cnt = dly_of(m_ien[1:0]); end
      else if (m_act && tk) m_cnt = m_cnt - 1;
    end
    if (wr) begin
      case (a)
        5'h10: m_boot = d[2:1];
        5'h14: m_boot = m_boot | d[2:1];
        5'h1C: m_ien  = d & EM;
        default: ;
      endcase
    end
    m_rst = imm || fin;
    m_irq = m_ien[7] && |(m_pend & m_ien & IM);
    @(posedge clk); @(negedge clk);
    src_evt = 0; lpo_tick = 0; bus_wr = 0;
    chk(sys_rst_o == m_rst, "R10 R5 sys_rst_o", {31'h0, sys_rst_o}, {31'h0, m_rst});
    chk(irq_o == m_irq, "R4 irq_o", {31'h0, irq_o}, {31'h0, m_irq});
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cyc(16'h0, 1'b0, 1'b1, a, d);
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(16'h0, 1'b1, 1'b0, 5'h0, 32'h0);
  endtask

  initial begin
    #(10 * 200000);
    if (!done_flag) begin
      done_flag = 1;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    por_n = 0; lpo_tick = 0; bus_wr = 0; src_evt = 0; bus_addr = 0; bus_wdata = 0;
    m_stat = 32'h82; m_stk = 32'h82; m_pend = 0; m_ien = 0; m_boot = 0;
    m_act = 0; m_rst = 0; m_irq = 0; m_cnt = 0;
    repeat (5) @(negedge clk);
    por_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(5'h00, {8'(MAJ), 8'(MIN), 16'h0003}, "R1 version");
    rd(5'h08, 32'h82, "R1 status");
    rd(5'h18, 32'h82, "R1 sticky");
    rd(5'h1C, 32'h0, "R1 ien");
    rd(5'h10, 32'h0, "R1 mode");
    chk(!irq_o && !sys_rst_o, "R1 outputs", {30'h0, irq_o, sys_rst_o}, 32'h0);
    // R11 unmapped
    rd(5'h04, 32'h0, "R11 unmapped 0x04");
    rd(5'h0C, 32'h0, "R11 unmapped 0x0C");

    // R8 sticky write-one-clear, read-only registers
    wr(5'h18, 32'h0);
    rd(5'h18, 32'h82, "R8 sticky write zero");
    wr(5'h18, 32'h80);
    rd(5'h18, 32'h02, "R8 sticky clear bit7");
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, 32'h82, "R8 status read-only");
    wr(5'h00, 32'h0);
    rd(5'h00, {8'(MAJ), 8'(MIN), 16'h0003}, "R8 version read-only");

    // R9 boot mode / force
    wr(5'h14, 32'h2);
    rd(5'h10, 32'h2, "R9 force bit1");
    wr(5'h14, 32'h4);
    rd(5'h10, 32'h6, "R9 force ORs");
    rd(5'h14, 32'h0, "R9 force reads 0");
    wr(5'h10, 32'h4);
    rd(5'h10, 32'h4, "R9 mode replaces");

    // R5 immediate reset with interrupts off
    cyc(16'h0020, 1'b0, 1'b0, 5'h0, 32'h0);
    chk(sys_rst_o == 1'b1, "R5 immediate watchdog", {31'h0, sys_rst_o}, 32'h1);
    cyc(16'h0, 1'b0, 1'b0, 5'h0, 32'h0);
    chk(sys_rst_o == 1'b0, "R10 one-cycle pulse", {31'h0, sys_rst_o}, 32'h0);
    rd(5'h08, 32'h20, "R7 status replaced");
    rd(5'h18, 32'h22, "R7 sticky accumulates");

    // R3 code 0: 10 ticks
    wr(5'h1C, 32'hA0);
    cyc(16'h0020, 1'b0, 1'b0, 5'h0, 32'h0);
    chk(irq_o == 1'b1, "R4 irq raised", {31'h0, irq_o}, 32'h1);
    ticks(9);
    chk(sys_rst_o == 1'b0, "R3 no fire at tick 9", {31'h0, sys_rst_o}, 32'h0);
    ticks(1);
    chk(sys_rst_o == 1'b1, "R3 fire at tick 10", {31'h0, sys_rst_o}, 32'h1);
    chk(irq_o == 1'b0, "R10 pending cleared", {31'h0, irq_o}, 32'h0);

    // R6 second request does not restart (code 1, 34 ticks)
    wr(5'h1C, 32'hA5);
    cyc(16'h0020, 1'b0, 1'b0, 5'h0, 32'h0);
    ticks(20);
    cyc(16'h0004, 1'b0, 1'b0, 5'h0, 32'h0);
    ticks(13);
    chk(sys_rst_o == 1'b0, "R6 no fire at tick 33", {31'h0, sys_rst_o}, 32'h0);
    ticks(1);
    chk(sys_rst_o == 1'b1, "R6 fire at first delay end", {31'h0, sys_rst_o}, 32'h1);
    rd(5'h08, 32'h24, "R6 both causes recorded");

    // R2 unused event positions ignored
    cyc(16'hD191, 1'b1, 1'b0, 5'h0, 32'h0);
    ticks(3);
    chk(sys_rst_o == 1'b0 && irq_o == 1'b0, "R2 unused bits no output",
        {30'h0, irq_o, sys_rst_o}, 32'h0);
    rd(5'h08, 32'h24, "R2 status unchanged");
    rd(5'h18, m_stk, "R2 sticky unchanged");

    // R5 low-voltage bit always immediate, also mid-countdown
    wr(5'h1C, 32'hA0);
    cyc(16'h0020, 1'b0, 1'b0, 5'h0, 32'h0);
    ticks(3);
    cyc(16'h0002, 1'b0, 1'b0, 5'h0, 32'h0);
    chk(sys_rst_o == 1'b1, "R5 low-voltage immediate", {31'h0, sys_rst_o}, 32'h1);
    rd(5'h08, 32'h22, "R7 pending plus new cause");
    // R5 enabled source but global enable clear
    wr(5'h1C, 32'h20);
    cyc(16'h0020, 1'b0, 1'b0, 5'h0, 32'h0);
    chk(sys_rst_o == 1'b1, "R5 gie clear immediate", {31'h0, sys_rst_o}, 32'h1);

    // R3 code 3: 514 ticks
    wr(5'h1C, 32'h2083);
    cyc(16'h2000, 1'b0, 1'b0, 5'h0, 32'h0);
    ticks(513);
    chk(sys_rst_o == 1'b0, "R3 no fire at tick 513", {31'h0, sys_rst_o}, 32'h0);
    ticks(1);
    chk(sys_rst_o == 1'b1, "R3 fire at tick 514", {31'h0, sys_rst_o}, 32'h1);
    rd(5'h08, 32'h2000, "R7 stop-ack cause");

    // random traffic against the model
    for (int k = 0; k < 4000; k++) begin
      logic [15:0] ev;
      logic        w;
      logic [4:0]  a;
      logic [31:0] d;
      ev = ($urandom % 30 == 0) ? (16'h1 << ($urandom % 16)) : 16'h0;
      w  = ($urandom % 25 == 0);
      a  = 5'h0;
      d  = $urandom;
      if (w) begin
        case ($urandom % 5)
          0: a = 5'h1C;
          1: a = 5'h18;
          2: a = 5'h10;
          3: a = 5'h14;
          default: a = 5'h08;
        endcase
        if (a == 5'h1C) d = (d & 32'hFFFF_FFFC) | 32'($urandom % 2) | 32'h80;
      end
      cyc(ev, 1'($urandom % 2), w, a, d);
      if (k % 64 == 63) begin
        rd(5'h08, m_stat, "R7 random status");
        rd(5'h18, m_stk, "R8 random sticky");
        rd(5'h1C, m_ien, "R4 random ien");
        rd(5'h10, {29'h0, m_boot, 1'b0}, "R9 random mode");
      end
    end

    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule